// File: doc/BRIEF.md
# Storage Host Interrupt Status Unit

This block gathers the event sources of a parallel storage host controller into one interrupt status register that a CPU reads and clears over a simple register bus. Six sources (transfer complete, device interrupt, two buffer levels and two DMA-class stall conditions) are latched and held until software writes a one to the matching bit. Two further bits record a bus backoff request from a shared external bus. These bits follow the bus arbitration rather than software, and clear themselves when the controller hands the external bus back. Two more bits record a transfer that was aborted by such a backoff. Every backoff-related event lands in a read-side or a write-side bit, chosen by the transfer direction input at the time of the event.

A mask register selects which status bits drive the single interrupt line to the CPU. A one-bit software reset register drives a reset level to the rest of the host controller. While that bit is set, the status register is held clear, and the mask and reset bit keep their values. The asynchronous active-low reset input is released to the internal logic through a small synchroniser.

Top module: `stor_irq_top`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is 0 and `host_rst_o` is 0. Unused bit positions of every register read 0.
- R2: A status bit is set in the cycle after its source is high. Sticky bits stay set for as long as no clear reaches them. The event sources map to status bits as follows: `evt_done`=bit0, `evt_udma_term`=bit1, `evt_dev_irq`=bit2, `evt_tbuf_half`=bit3, `evt_sbuf_empty`=bit4, `evt_mdma_hold`=bit5.
- R3: The status register sits at byte offset 0x0. A bus write there clears each of bits 0–5, 8 and 9 where the written data holds a 1. A written 0 leaves a bit unchanged, and a write never sets a bit.
- R4: When a source event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R5: `bkoff_req` sets bit 6 when `xfer_rd`=0 and bit 7 when `xfer_rd`=1. Bus writes do not clear bits 6 and 7. A high `ext_bus_rel` clears them in the next cycle, unless a new request sets them in the same cycle.
- R6: `bkoff_abort` sets bit 8 when `xfer_rd`=0 and bit 9 when `xfer_rd`=1. Both bits are sticky, cleared by write-one only, and unaffected by `ext_bus_rel`.
- R7: The mask register sits at byte offset 0x4 and holds bits [9:0], which can be read and written. `irq_o` is high exactly when some status bit and its mask bit are both 1.
- R8: The software reset register sits at byte offset 0x8 and holds bit 0, which can be read and written. `host_rst_o` equals that bit. While the bit is 1, the status register clears and ignores source events, and the mask register and the bit itself keep their values.
- R9: Byte offset 0xC reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| evt_done | input | 1 | All transfers complete |
| evt_udma_term | input | 1 | Device ended an ultra DMA burst early |
| evt_dev_irq | input | 1 | Device interrupt request |
| evt_tbuf_half | input | 1 | Track buffer reached half full |
| evt_sbuf_empty | input | 1 | Source buffer empty |
| evt_mdma_hold | input | 1 | Device paused a multiword DMA transfer |
| bkoff_req | input | 1 | External bus requests backoff |
| bkoff_abort | input | 1 | Transfer aborted by backoff |
| xfer_rd | input | 1 | Transfer direction, 1 = read |
| ext_bus_rel | input | 1 | Controller releases the external bus |
| irq_o | output | 1 | Combined masked interrupt |
| host_rst_o | output | 1 | Reset level to the host controller |

## Verification
The assertions assume that `xfer_rd` is valid in every cycle where `bkoff_req` or `bkoff_abort` is high. They also assume that a register write lasts one cycle with `bus_sel` and `bus_wr` high together. The stimulus raises each source for exactly one clock and sets the direction in that same cycle. It places bus writes between events, except where a collision between a set and a clear is the thing under test. It also issues source events while the software reset bit is held, to show that they are dropped.

// File: rtl/stor_irq_pkg.sv
package stor_irq_pkg;
  localparam int NSRC = 10;

  localparam int BIT_DONE      = 0;
  localparam int BIT_UDMA_TERM = 1;
  localparam int BIT_DEV_IRQ   = 2;
  localparam int BIT_TBUF_HALF = 3;
  localparam int BIT_SBUF_EMP  = 4;
  localparam int BIT_MDMA_HOLD = 5;
  localparam int BIT_BKOFF_WR  = 6;
  localparam int BIT_BKOFF_RD  = 7;
  localparam int BIT_ABORT_WR  = 8;
  localparam int BIT_ABORT_RD  = 9;

  // bits that clear on bus release instead of by software
  localparam logic [NSRC-1:0] AUTO_CLR_MASK = 10'h0C0;

  // word indices of the registers
  localparam int REG_STAT = 0;
  localparam int REG_MASK = 1;
  localparam int REG_SRST = 2;
endpackage

// File: rtl/stor_irq_rstsync.sv
module stor_irq_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/stor_irq_regif.sv
module stor_irq_regif
  import stor_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSRC-1:0]   stat_i,
  input  logic [NSRC-1:0]   mask_i,
  input  logic              srst_i,
  output logic [NSRC-1:0]   w1c_o,
  output logic              mask_we_o,
  output logic              srst_we_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             wr_en;
  logic             unused_bits;

  assign idx         = addr_i[ADDR_W-1:2];
  assign wr_en       = sel_i & wr_i;
  assign unused_bits = ^{addr_i[1:0], wdata_i[DATA_W-1:NSRC]};

  always_comb begin
    w1c_o     = '0;
    mask_we_o = 1'b0;
    srst_we_o = 1'b0;
    if (wr_en) begin
      if (idx == IDX_W'(REG_STAT)) w1c_o     = wdata_i[NSRC-1:0];
      if (idx == IDX_W'(REG_MASK)) mask_we_o = 1'b1;
      if (idx == IDX_W'(REG_SRST)) srst_we_o = 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (idx == IDX_W'(REG_STAT))      rdata_o = DATA_W'(stat_i);
    else if (idx == IDX_W'(REG_MASK)) rdata_o = DATA_W'(mask_i);
    else if (idx == IDX_W'(REG_SRST)) rdata_o = DATA_W'(srst_i);
  end
endmodule

// File: rtl/stor_irq_ctl.sv
module stor_irq_ctl
  import stor_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              mask_we_i,
  input  logic              srst_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NSRC-1:0]   mask_o,
  output logic              srst_o
);
  logic [NSRC-1:0] mask_q, mask_d;
  logic            srst_q, srst_d;

  always_comb begin
    mask_d = mask_q;
    srst_d = srst_q;
    if (mask_we_i) mask_d = wdata_i[NSRC-1:0];
    if (srst_we_i) srst_d = wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      srst_q <= 1'b0;
    end else begin
      mask_q <= mask_d;
      srst_q <= srst_d;
    end
  end

  assign mask_o = mask_q;
  assign srst_o = srst_q;

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_o)); // R7
  AST_SRST_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !srst_we_i |=> $stable(srst_o)); // R8
endmodule

// File: rtl/stor_irq_status.sv
module stor_irq_status
  import stor_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic            srst_i,
  output logic [NSRC-1:0] stat_o
);
  logic [NSRC-1:0] stat_q, stat_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_comb begin
      if (srst_i)        stat_d[i] = 1'b0;
      else if (set_i[i]) stat_d[i] = 1'b1;
      else if (clr_i[i]) stat_d[i] = 1'b0;
      else               stat_d[i] = stat_q[i];
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_ni)
      (set_i[i] && !srst_i) |=> stat_o[i]); // R4
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !stat_o[i]); // R3
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
      (stat_o[i] && !clr_i[i] && !srst_i) |=> stat_o[i]); // R2
    AST_SRST_CLR: assert property (@(posedge clk) disable iff (!rst_ni)
      srst_i |=> !stat_o[i]); // R8
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/stor_irq_top.sv
module stor_irq_top
  import stor_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              evt_done,
  input  logic              evt_udma_term,
  input  logic              evt_dev_irq,
  input  logic              evt_tbuf_half,
  input  logic              evt_sbuf_empty,
  input  logic              evt_mdma_hold,
  input  logic              bkoff_req,
  input  logic              bkoff_abort,
  input  logic              xfer_rd,
  input  logic              ext_bus_rel,
  output logic              irq_o,
  output logic              host_rst_o
);
  logic            rst_ni;
  logic [NSRC-1:0] set_vec, clr_vec, w1c_vec, stat_q, mask_q;
  logic            mask_we, srst_we, srst_q;

  stor_irq_rstsync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_no(rst_ni)
  );

  always_comb begin
    set_vec                = '0;
    set_vec[BIT_DONE]      = evt_done;
    set_vec[BIT_UDMA_TERM] = evt_udma_term;
    set_vec[BIT_DEV_IRQ]   = evt_dev_irq;
    set_vec[BIT_TBUF_HALF] = evt_tbuf_half;
    set_vec[BIT_SBUF_EMP]  = evt_sbuf_empty;
    set_vec[BIT_MDMA_HOLD] = evt_mdma_hold;
    set_vec[BIT_BKOFF_WR]  = bkoff_req & ~xfer_rd;
    set_vec[BIT_BKOFF_RD]  = bkoff_req & xfer_rd;
    set_vec[BIT_ABORT_WR]  = bkoff_abort & ~xfer_rd;
    set_vec[BIT_ABORT_RD]  = bkoff_abort & xfer_rd;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_clr
    if (AUTO_CLR_MASK[i]) begin : g_auto
      assign clr_vec[i] = ext_bus_rel;
    end else begin : g_w1c
      assign clr_vec[i] = w1c_vec[i];
    end
  end

  stor_irq_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .stat_i(stat_q), .mask_i(mask_q), .srst_i(srst_q),
    .w1c_o(w1c_vec), .mask_we_o(mask_we), .srst_we_o(srst_we),
    .rdata_o(bus_rdata)
  );

  stor_irq_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_ni(rst_ni), .mask_we_i(mask_we), .srst_we_i(srst_we),
    .wdata_i(bus_wdata), .mask_o(mask_q), .srst_o(srst_q)
  );

  stor_irq_status u_status (
    .clk(clk), .rst_ni(rst_ni), .set_i(set_vec), .clr_i(clr_vec),
    .srst_i(srst_q), .stat_o(stat_q)
  );

  assign irq_o      = |(stat_q & mask_q);
  assign host_rst_o = srst_q;

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_o |-> (mask_q != '0)); // R7
  AST_IRQ_NEEDS_STAT: assert property (@(posedge clk) disable iff (!rst_ni)
    irq_o |-> (stat_q != '0)); // R7
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(host_rst_o) |-> !irq_o); // R8
  AST_AUTO_WR_IGN: assert property (@(posedge clk) disable iff (!rst_ni)
    (stat_q[BIT_BKOFF_RD] && !ext_bus_rel && !srst_q) |=> stat_q[BIT_BKOFF_RD]); // R5
endmodule

// File: tb/stor_irq_top_tb.sv
module stor_irq_top_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [5:0]  evt = 0;
  logic        bk_req = 0, bk_abort = 0, dir = 0, rel = 0;
  logic        irq_o, host_rst_o;

  typedef struct {
    int          kind;   // 0 read data, 1 irq, 2 host reset
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  logic  probe = 0;
  int    n_run = 0, n_fail = 0;
  bit    done = 0;

  always #5 clk = ~clk;

  stor_irq_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_done(evt[0]), .evt_udma_term(evt[1]), .evt_dev_irq(evt[2]),
    .evt_tbuf_half(evt[3]), .evt_sbuf_empty(evt[4]), .evt_mdma_hold(evt[5]),
    .bkoff_req(bk_req), .bkoff_abort(bk_abort), .xfer_rd(dir),
    .ext_bus_rel(rel), .irq_o(irq_o), .host_rst_o(host_rst_o)
  );

  // monitor
  always @(negedge clk) begin
    if (probe && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = bus_rdata;
        1:       act = {31'b0, irq_o};
        default: act = {31'b0, host_rst_o};
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  // one cycle of stimulus, optionally with a bus write
  task automatic cyc(input logic [5:0] e, input logic b, input logic a,
                     input logic d, input logic r, input logic w,
                     input logic [3:0] ad, input logic [31:0] wd);
    @(posedge clk); #2;
    evt = e; bk_req = b; bk_abort = a; dir = d; rel = r;
    bus_sel = w; bus_wr = w; bus_addr = ad; bus_wdata = wd;
    @(posedge clk); #2;
    evt = 0; bk_req = 0; bk_abort = 0; rel = 0;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic wr(input logic [3:0] ad, input logic [31:0] wd);
    cyc(6'h0, 0, 0, 0, 0, 1, ad, wd);
  endtask

  task automatic chk(input int kind, input logic [3:0] ad,
                     input logic [31:0] exp, input string tag);
    item_t it;
    @(posedge clk); #2;
    if (kind == 0) begin bus_sel = 1; bus_wr = 0; bus_addr = ad; end
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    probe = 1;
    @(negedge clk); #1;
    probe = 0; bus_sel = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 reset state
    chk(0, 4'h0, 32'h0, "R1 status");
    chk(0, 4'h4, 32'h0, "R1 mask");
    chk(0, 4'h8, 32'h0, "R1 swreset");
    chk(1, 4'h0, 32'h0, "R1 irq");
    chk(2, 4'h0, 32'h0, "R1 host reset");

    // R2 sticky set
    cyc(6'h09, 0, 0, 0, 0, 0, 4'h0, 0);
    chk(0, 4'h0, 32'h009, "R2 set");
    repeat (3) @(posedge clk);
    chk(0, 4'h0, 32'h009, "R2 held");

    // R3 write one to clear
    wr(4'h0, 32'h0);
    chk(0, 4'h0, 32'h009, "R3 zero write");
    wr(4'h0, 32'h1);
    chk(0, 4'h0, 32'h008, "R3 clear bit0");
    wr(4'h0, 32'h3F4);
    chk(0, 4'h0, 32'h008, "R3 no set by write");
    wr(4'h0, 32'h8);
    chk(0, 4'h0, 32'h000, "R3 clear bit3");

    // R4 set beats clear
    cyc(6'h04, 0, 0, 0, 0, 1, 4'h0, 32'h4);
    chk(0, 4'h0, 32'h004, "R4 collision");
    wr(4'h0, 32'h4);

    // R5 backoff bits
    cyc(6'h0, 1, 0, 0, 0, 0, 4'h0, 0);
    chk(0, 4'h0, 32'h040, "R5 write-side backoff");
    wr(4'h0, 32'h0C0);
    chk(0, 4'h0, 32'h040, "R5 write ignored");
    cyc(6'h0, 1, 0, 1, 0, 0, 4'h0, 0);
    chk(0, 4'h0, 32'h0C0, "R5 read-side backoff");
    cyc(6'h0, 0, 0, 0, 1, 0, 4'h0, 0);
    chk(0, 4'h0, 32'h000, "R5 release clears");
    cyc(6'h0, 1, 0, 1, 1, 0, 4'h0, 0);
    chk(0, 4'h0, 32'h080, "R5 set beats release");
    cyc(6'h0, 0, 0, 0, 1, 0, 4'h0, 0);
    chk(0, 4'h0, 32'h000, "R5 release again");

    // R6 abort bits
    cyc(6'h0, 0, 1, 0, 0, 0, 4'h0, 0);
    chk(0, 4'h0, 32'h100, "R6 write abort");
    cyc(6'h0, 0, 1, 1, 0, 0, 4'h0, 0);
    chk(0, 4'h0, 32'h300, "R6 read abort");
    cyc(6'h0, 0, 0, 0, 1, 0, 4'h0, 0);
    chk(0, 4'h0, 32'h300, "R6 release no effect");
    wr(4'h0, 32'h100);
    chk(0, 4'h0, 32'h200, "R6 clear write abort");
    wr(4'h0, 32'h200);
    chk(0, 4'h0, 32'h000, "R6 clear read abort");

    // R7 mask and irq
    cyc(6'h02, 0, 0, 0, 0, 0, 4'h0, 0);
    chk(1, 4'h0, 32'h0, "R7 irq masked");
    wr(4'h4, 32'hFFFF_FFFF);
    chk(0, 4'h4, 32'h3FF, "R7 mask readback");
    chk(1, 4'h0, 32'h1, "R7 irq enabled");
    wr(4'h4, 32'h1);
    chk(1, 4'h0, 32'h0, "R7 other bit masked");
    wr(4'h4, 32'h2);
    chk(1, 4'h0, 32'h1, "R7 matching mask");
    wr(4'h0, 32'h2);
    chk(1, 4'h0, 32'h0, "R7 irq drops");

    // R8 software reset
    cyc(6'h10, 0, 0, 0, 0, 0, 4'h0, 0);
    wr(4'h8, 32'h1);
    chk(2, 4'h0, 32'h1, "R8 strobe high");
    chk(0, 4'h8, 32'h1, "R8 bit readback");
    chk(0, 4'h0, 32'h0, "R8 status cleared");
    cyc(6'h20, 0, 1, 1, 0, 0, 4'h0, 0);
    chk(0, 4'h0, 32'h0, "R8 events ignored");
    chk(0, 4'h4, 32'h2, "R8 mask kept");
    wr(4'h8, 32'h0);
    chk(2, 4'h0, 32'h0, "R8 strobe low");
    cyc(6'h20, 0, 0, 0, 0, 0, 4'h0, 0);
    chk(0, 4'h0, 32'h020, "R8 events resume");

    // R9 unmapped offset
    chk(0, 4'hC, 32'h0, "R9 read zero");
    wr(4'hC, 32'hFFFF_FFFF);
    chk(0, 4'h4, 32'h2, "R9 mask untouched");
    chk(0, 4'h8, 32'h0, "R9 swreset untouched");
    chk(0, 4'h0, 32'h020, "R9 status untouched");

    repeat (2) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule